// File: doc/BRIEF.md
# Maskable Sticky Video Error Flag

This block sits behind the error detectors of a serial video receiver. Each detector raises a one-cycle pulse on its own line of an error vector. The block records every monitored pulse in a sticky status word. It also drives an active-low summary pin that stays low while any monitored status bit is set. The status word clears at the next frame or field start, or when the host reads it. A read returns the word as it stood before the clear.

A mask register selects which detectors are monitored. Every mask bit is high after reset. The same block also produces an active-low load strobe for an external FIFO. The strobe pulses low for a single pixel clock after a start-of-active-video detect. All logic runs on the pixel clock, and reset is synchronous and active-high.

Top module: `vid_err_flag`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes all zeros, the mask becomes all ones, and `err_n` and `fifo_ld_n` read 1 after that edge.
- R2: A pulse on `err_pulse[i]` while mask bit i is 1 sets `stat_word[i]` at the next edge. The bit then stays 1 until a clear.
- R3: `err_n` is 0 exactly when some status bit with its mask bit at 1 is set, and 1 otherwise.
- R4: `frame_start` high at an edge clears every status bit that is not being set in the same cycle.
- R5: While `stat_rd` is high, `stat_word` shows the value held before the read. Bits not being set in that cycle are 0 after the edge.
- R6: An error pulse in the same cycle as a clear (frame start or read) wins, and its status bit is 1 after that edge.
- R7: A pulse on a source whose mask bit is 0 leaves its status bit unchanged.
- R8: Writing a mask bit to 0 keeps an already-set status bit at 1, and that bit no longer pulls `err_n` low.
- R9: `fifo_ld_n` is 0 for the one cycle after each edge at which `sav_det` is high, and 1 after edges at which `sav_det` is low.
- R10: `mask_wr` high at an edge loads `mask_wdata` into the mask, and the new mask governs pulses from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pulse | input | NUM_ERR | One-cycle error-detect pulses, one per source |
| frame_start | input | 1 | Frame/field start pulse, clears status |
| sav_det | input | 1 | Start of active video detected |
| stat_rd | input | 1 | Host read strobe of the status word, clears after read |
| mask_wr | input | 1 | Mask register write enable |
| mask_wdata | input | NUM_ERR | Mask value to write, 1 = monitored |
| stat_word | output | NUM_ERR | Sticky error status word |
| err_n | output | 1 | Active-low summary of monitored status bits |
| fifo_ld_n | output | 1 | Active-low one-cycle FIFO load strobe |

## Verification
Status bits, the mask and the load strobe all change at the first edge after their stimulus. `err_n` follows the registered status and mask with no further delay, so it moves in that same edge. The driver applies each stimulus at a falling edge and queues the outputs expected just after the next rising edge. The monitor pops that entry 1 ns after the rising edge. The pre-clear value during a read is checked separately, before the edge, in the read cycle itself.

// File: rtl/vid_err_pkg.sv
package vid_err_pkg;

    // Causes that empty the sticky status word at the next edge.
    typedef struct packed {
        logic frame;
        logic read;
    } clr_req_t;

    function automatic logic any_clear(input clr_req_t c);
        return c.frame | c.read;
    endfunction

endpackage

// File: rtl/err_mask_reg.sv
module err_mask_reg #(
    parameter int NUM_ERR = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [NUM_ERR-1:0] wdata,
    output logic [NUM_ERR-1:0] mask
);
    typedef struct packed {
        logic [NUM_ERR-1:0] bits;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits = wdata;
        end
        if (rst) begin
            st_d.bits = '1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mask = st_q.bits;
endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank
    import vid_err_pkg::*;
#(
    parameter int NUM_ERR = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  clr_req_t           clr,
    input  logic [NUM_ERR-1:0] err_in,
    input  logic [NUM_ERR-1:0] mask,
    output logic [NUM_ERR-1:0] sticky
);
    typedef struct packed {
        logic [NUM_ERR-1:0] bits;
    } bank_state_t;

    bank_state_t        st_d, st_q;
    logic [NUM_ERR-1:0] bit_next;
    logic               wipe;

    assign wipe = any_clear(clr);

    // Per-source next value: a monitored pulse sets, a clear empties,
    // and a set in the same cycle as a clear prevails.
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_bit
        logic hold;
        logic set;
        assign hold        = st_q.bits[i] & ~wipe;
        assign set         = err_in[i] & mask[i];
        assign bit_next[i] = hold | set;
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = bit_next;
        if (rst) begin
            st_d.bits = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sticky = st_q.bits;
endmodule

// File: rtl/sav_strobe.sv
module sav_strobe (
    input  logic clk,
    input  logic rst,
    input  logic sav,
    output logic strobe_n
);
    typedef struct packed {
        logic ld_n;
    } strobe_state_t;

    strobe_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ld_n = ~sav;
        if (rst) begin
            st_d.ld_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign strobe_n = st_q.ld_n;
endmodule

// File: rtl/vid_err_flag.sv
module vid_err_flag
    import vid_err_pkg::*;
#(
    parameter int NUM_ERR = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ERR-1:0] err_pulse,
    input  logic               frame_start,
    input  logic               sav_det,
    input  logic               stat_rd,
    input  logic               mask_wr,
    input  logic [NUM_ERR-1:0] mask_wdata,
    output logic [NUM_ERR-1:0] stat_word,
    output logic               err_n,
    output logic               fifo_ld_n
);
    logic [NUM_ERR-1:0] mask_q;
    logic [NUM_ERR-1:0] sticky_q;
    logic [NUM_ERR-1:0] watched;
    clr_req_t           clr;

    always_comb begin
        clr.frame = frame_start;
        clr.read  = stat_rd;
    end

    err_mask_reg #(.NUM_ERR(NUM_ERR)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr_en (mask_wr),
        .wdata (mask_wdata),
        .mask  (mask_q)
    );

    err_sticky_bank #(.NUM_ERR(NUM_ERR)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .err_in (err_pulse),
        .mask   (mask_q),
        .sticky (sticky_q)
    );

    sav_strobe u_sav (
        .clk      (clk),
        .rst      (rst),
        .sav      (sav_det),
        .strobe_n (fifo_ld_n)
    );

    assign watched   = sticky_q & mask_q;
    assign err_n     = ~(|watched);
    assign stat_word = sticky_q;
endmodule

// File: rtl/vid_err_flag_chk.sv
module vid_err_flag_chk #(
    parameter int NUM_ERR = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_ERR-1:0] err_pulse,
    input logic               frame_start,
    input logic               stat_rd,
    input logic               sav_det,
    input logic [NUM_ERR-1:0] mask_q,
    input logic [NUM_ERR-1:0] stat_word,
    input logic               err_n,
    input logic               fifo_ld_n
);
    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (|(err_pulse & mask_q)) |=>
            ((stat_word & $past(err_pulse & mask_q)) == $past(err_pulse & mask_q)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !stat_rd) |=>
            ((stat_word & $past(stat_word)) == $past(stat_word)));

    assert_low_needs_bit_R3: assert property (@(posedge clk) disable iff (rst)
        !err_n |-> (stat_word != '0));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        ((frame_start || stat_rd) && err_pulse == '0) |=> (stat_word == '0));

    assert_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((stat_word & ~$past(stat_word) & ~$past(mask_q)) == '0));

    assert_strobe_low_R9: assert property (@(posedge clk) disable iff (rst)
        sav_det |=> !fifo_ld_n);

    assert_strobe_high_R9: assert property (@(posedge clk) disable iff (rst)
        !sav_det |=> fifo_ld_n);
endmodule

bind vid_err_flag vid_err_flag_chk #(.NUM_ERR(NUM_ERR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .err_pulse   (err_pulse),
    .frame_start (frame_start),
    .stat_rd     (stat_rd),
    .sav_det     (sav_det),
    .mask_q      (mask_q),
    .stat_word   (stat_word),
    .err_n       (err_n),
    .fifo_ld_n   (fifo_ld_n)
);

// File: tb/vid_err_flag_test.sv
`timescale 1ns/1ps
module vid_err_flag_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] err_pulse = '0;
    logic         frame_start = 1'b0;
    logic         sav_det = 1'b0;
    logic         stat_rd = 1'b0;
    logic         mask_wr = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic [N-1:0] stat_word;
    logic         err_n;
    logic         fifo_ld_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state built from the requirements.
    logic [N-1:0] m_stat = '0;
    logic [N-1:0] m_mask = '1;
    logic         m_fifo = 1'b1;

    logic [N-1:0] q_stat[$];
    logic         q_errn[$];
    logic         q_fifo[$];
    string        q_tag[$];

    always #2.5 clk = ~clk;

    vid_err_flag #(.NUM_ERR(N)) uut (
        .clk(clk), .rst(rst), .err_pulse(err_pulse), .frame_start(frame_start),
        .sav_det(sav_det), .stat_rd(stat_rd), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .stat_word(stat_word), .err_n(err_n),
        .fifo_ld_n(fifo_ld_n)
    );

    // Driver: apply one cycle of stimulus and queue the post-edge outputs.
    task automatic step(input logic r, input logic [N-1:0] e, input logic fs,
                        input logic sv, input logic rd, input logic mw,
                        input logic [N-1:0] md, input string tag);
        @(negedge clk);
        rst = r; err_pulse = e; frame_start = fs; sav_det = sv;
        stat_rd = rd; mask_wr = mw; mask_wdata = md;
        if (rd && !r) begin
            checks++;
            if (stat_word !== m_stat) begin
                fails++;
                $display("FAIL %s read value: actual %h expected %h", tag, stat_word, m_stat);
            end
        end
        if (r) begin
            m_stat = '0; m_mask = '1; m_fifo = 1'b1;
        end else begin
            m_stat = (((fs | rd) ? '0 : m_stat) | (e & m_mask));
            m_fifo = ~sv;
            if (mw) m_mask = md;
        end
        q_stat.push_back(m_stat);
        q_errn.push_back(~(|(m_stat & m_mask)));
        q_fifo.push_back(m_fifo);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    // Monitor: pop and compare just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q_tag.size() > 0) begin
            logic [N-1:0] es; logic ee; logic ef; string t;
            es = q_stat.pop_front(); ee = q_errn.pop_front();
            ef = q_fifo.pop_front(); t = q_tag.pop_front();
            checks++;
            if (stat_word !== es || err_n !== ee || fifo_ld_n !== ef) begin
                fails++;
                $display("FAIL %s: actual stat=%h err_n=%b fifo_ld_n=%b expected stat=%h err_n=%b fifo_ld_n=%b",
                         t, stat_word, err_n, fifo_ld_n, es, ee, ef);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(1'b1, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1 reset");
        step(1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R1 reset dominates");
        step(1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 R3 set bit3");
        idle("R2 sticky hold");
        step(1'b0, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 set bits 0 and 7");
        idle("R3 err_n low");
        step(1'b0, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R5 R6 read with set bit1");
        step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, "R5 read clears");
        step(1'b0, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R2 set bit6");
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R4 frame clears");
        idle("R3 err_n high");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0F, "R10 mask write");
        step(1'b0, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7 masked pulses ignored");
        step(1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0E, "R10 old mask governs write cycle");
        idle("R8 bit kept, err_n high");
        step(1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R6 frame with set bit2");
        idle("R3 monitored bit2");
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R9 sav strobe");
        idle("R9 strobe back high");
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R9 sav again");
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R9 sav consecutive");
        idle("R9 high after run");
        step(1'b1, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1 reset mid-run");
        step(1'b0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1 mask all ones after reset");
        idle("R2 final hold");
        idle("drain");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule